// File: doc/BRIEF.md
# Serial Memory Bus Slave Front End

This block is the bus-facing half of a two-wire serial memory. It oversamples SCL and SDA with a fast system clock and filters out short spikes on both lines. It then finds START, repeated START and STOP conditions. A short register-based array sits behind it and stands in for the nonvolatile cells. The master owns the clock and every condition. The slave only acknowledges, and on reads it pulls SDA low to send zero bits.

An access opens with a device byte. It carries a fixed four-bit prefix, three strap bits and a direction bit. A write goes on with two address bytes and then data bytes, which wrap inside their page. A read is normally started with a dummy write that sets the address, then a repeated START and a read device byte. The slave streams bytes until the master answers with a NACK. After any write the slave runs a timed internal write cycle and will not answer its own address, so a master can poll for completion. The slave also stays silent for a fixed time after reset. With the default `ADDR_W` of 8, only the low address bits select a cell. Setting 14 gives a full 16 KiB space.

Top module: `i2c_ee_slave`

## Requirements
- R1: During the first `PWRUP_CYC` clocks after reset, the slave acknowledges nothing and keeps `sda_oe` at 0. `sda_oe` is 0 straight out of reset.
- R2: A pulse on SCL or SDA is ignored if it lasts fewer than `FILT_CYC` clocks. Such a pulse never adds a bit or creates a condition.
- R3: The slave acknowledges a device byte only when bits 7..4 are 1010 and bits 3..1 equal `strap_i`. Otherwise it sends NACK and ignores the bus until the next START or STOP.
- R4: In a write, a device byte with bit 0 at 0 is followed by an address high byte, an address low byte and data bytes. The slave acknowledges each byte. The address is sent MSB first, and only its low `ADDR_W` bits select a cell.
- R5: Successive data bytes of one write increment only the low `PAGE_W` address bits. The address wraps to the start of the same page.
- R6: A STOP that ends a write with at least one data byte starts a write cycle of `WRITE_CYC` clocks. During that cycle the slave does not acknowledge its address. Afterwards it acknowledges again.
- R7: A device byte with bit 0 at 1 makes the slave send the byte at the current address, MSB first. After a write sequence, that address is the one the write loaded.
- R8: After each byte read, the address increments across the whole array and rolls from the top cell to cell 0.
- R9: A NACK from the master after a read byte ends the read. After the following STOP, `sda_oe` is 0.
- R10: `sda_oe` changes only while SCL is low. Each change comes after a filtered SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset (supply-stable marker) |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| strap_i | input | 3 | Strap bits compared against the device byte |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A slip in the bit counter or in the state shows up at the ACK slot of the byte it hits. The slave either misses the ACK or drives a data bit where the master expects to release the line. Either way the master sees it at the next rising SCL. A wrong address pointer passes the ACKs but returns a different byte on the next read. So the page wrap, the rollover and aliasing are each checked by reading back values placed around the boundaries. A wrong busy or power-up counter appears as an ACK inside the quiet window, or a NACK after it, on the very first poll.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } ee_state_e;
endpackage

// File: rtl/i2c_ee_deglitch.sv
module i2c_ee_deglitch #(
    parameter int unsigned HOLD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          q;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = din;
        r_d.s2 = r_q.s1;
        if (r_q.s2 != r_q.q) begin
            if (r_q.cnt == CW'(HOLD - 1)) begin
                r_d.q   = r_q.s2;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1, q: 1'b1, cnt: '0};
        else        r_q <= r_d;
    end

    assign dout = r_q.q;

    AST_FILT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.q) |-> (r_q.q == $past(r_q.s2)));  // R2
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
    import i2c_ee_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned PAGE_W    = 6,
    parameter int unsigned FILT_CYC  = 20,
    parameter int unsigned WRITE_CYC = 1000000,
    parameter int unsigned PWRUP_CYC = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe
);
    localparam int unsigned WC_W = $clog2(WRITE_CYC + 1);
    localparam int unsigned PU_W = $clog2(PWRUP_CYC + 1);
    localparam int unsigned NLINE = 2;

    typedef struct packed {
        ee_state_e         st;
        logic [3:0]        bitcnt;
        logic              ackph;
        logic              oe;
        logic [7:0]        sh;
        logic [7:0]        hi;
        logic [ADDR_W-1:0] addr;
        logic              wrote;
        logic [WC_W-1:0]   wc;
        logic [PU_W-1:0]   pu;
        logic              sclp;
        logic              sdap;
    } core_t;

    core_t r_q, r_d;

    // line filters: index 0 = SCL, 1 = SDA
    logic [NLINE-1:0] raw, filt;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        i2c_ee_deglitch #(.HOLD(FILT_CYC)) u_flt (
            .clk (clk),
            .rst_n(rst_n),
            .din (raw[g]),
            .dout(filt[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt[0];
    assign sda_f = filt[1];

    logic rise, fall, start_ev, stop_ev, busy, ready;
    assign rise     = scl_f & ~r_q.sclp;
    assign fall     = ~scl_f & r_q.sclp;
    assign start_ev = scl_f & r_q.sclp & r_q.sdap & ~sda_f;
    assign stop_ev  = scl_f & r_q.sclp & ~r_q.sdap & sda_f;
    assign busy     = (r_q.wc != '0);
    assign ready    = (r_q.pu == PU_W'(PWRUP_CYC));

    logic       mem_we;
    logic [7:0] rdata;

    i2c_ee_array #(.AW(ADDR_W)) u_arr (
        .clk  (clk),
        .we   (mem_we),
        .waddr(r_q.addr),
        .wdata(r_q.sh),
        .raddr(r_q.addr),
        .rdata(rdata)
    );

    always_comb begin
        r_d      = r_q;
        mem_we   = 1'b0;
        r_d.sclp = scl_f;
        r_d.sdap = sda_f;
        if (!ready) r_d.pu = r_q.pu + 1'b1;
        if (busy)   r_d.wc = r_q.wc - 1'b1;

        if (stop_ev) begin
            r_d.st    = ST_IDLE;
            r_d.oe    = 1'b0;
            r_d.ackph = 1'b0;
            r_d.wrote = 1'b0;
            if (r_q.wrote) r_d.wc = WC_W'(WRITE_CYC);
        end else if (start_ev) begin
            r_d.st     = ST_DEV;
            r_d.bitcnt = '0;
            r_d.ackph  = 1'b0;
            r_d.oe     = 1'b0;
        end else if (r_q.st == ST_RDAT) begin
            if (rise) begin
                if (!r_q.ackph) begin
                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                end else begin
                    r_d.addr = r_q.addr + 1'b1;
                    if (sda_f) r_d.st = ST_IDLE;   // master NACK
                end
            end else if (fall) begin
                if (!r_q.ackph) begin
                    if (r_q.bitcnt == 4'd8) begin
                        r_d.oe    = 1'b0;
                        r_d.ackph = 1'b1;
                    end else begin
                        r_d.sh = {r_q.sh[6:0], 1'b0};
                        r_d.oe = ~r_q.sh[6];
                    end
                end else begin
                    r_d.ackph  = 1'b0;
                    r_d.bitcnt = '0;
                    r_d.sh     = rdata;
                    r_d.oe     = ~rdata[7];
                end
            end
        end else if (r_q.st != ST_IDLE) begin
            if (rise && !r_q.ackph && r_q.bitcnt < 4'd8) begin
                r_d.sh     = {r_q.sh[6:0], sda_f};
                r_d.bitcnt = r_q.bitcnt + 1'b1;
            end else if (fall && !r_q.ackph && r_q.bitcnt == 4'd8) begin
                r_d.ackph = 1'b1;
                r_d.oe    = 1'b1;
                unique case (r_q.st)
                    ST_DEV: begin
                        if (r_q.sh[7:1] != {DEV_PREFIX, strap_i} || !ready || busy) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_IDLE;
                        end
                    end
                    ST_AHI: r_d.hi   = r_q.sh;
                    ST_ALO: r_d.addr = ADDR_W'({r_q.hi, r_q.sh});
                    ST_WDAT: begin
                        mem_we                 = 1'b1;
                        r_d.wrote              = 1'b1;
                        r_d.addr[PAGE_W-1:0]   = r_q.addr[PAGE_W-1:0] + 1'b1;
                    end
                    default: ;
                endcase
            end else if (fall && r_q.ackph) begin
                r_d.ackph  = 1'b0;
                r_d.bitcnt = '0;
                r_d.oe     = 1'b0;
                unique case (r_q.st)
                    ST_DEV: begin
                        if (r_q.sh[0]) begin
                            r_d.st = ST_RDAT;
                            r_d.sh = rdata;
                            r_d.oe = ~rdata[7];
                        end else begin
                            r_d.st = ST_AHI;
                        end
                    end
                    ST_AHI:  r_d.st = ST_ALO;
                    ST_ALO:  r_d.st = ST_WDAT;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.sclp <= 1'b1;
            r_q.sdap <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.oe;

    AST_QUIET_PWRUP: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !sda_oe);  // R1
    AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);  // R6
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);  // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);  // R9
    AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && r_q.st != ST_RDAT) |-> r_q.ackph);  // R4
endmodule

// File: tb/i2c_ee_slave_bench.sv
`timescale 1ns/1ps
module i2c_ee_slave_bench;
    localparam int unsigned FILT = 20;
    localparam int unsigned WC   = 4000;
    localparam int unsigned PU   = 6000;
    localparam int unsigned Q    = 40;
    localparam int unsigned GL   = 10;
    localparam logic [7:0]  DEV_W = 8'hAA;   // 1010_101_0
    localparam logic [7:0]  DEV_R = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [2:0] strap = 3'b101;

    int n_chk = 0;
    int n_err = 0;
    int r10_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_ee_slave #(
        .ADDR_W(8), .PAGE_W(6), .FILT_CYC(FILT),
        .WRITE_CYC(WC), .PWRUP_CYC(PU)
    ) u_i2c_ee_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .strap_i(strap), .sda_oe(sda_oe)
    );

    // R10 monitor: drive changes only while the raw SCL is low
    logic oe_prev = 1'b0;
    always begin
        @(posedge clk);
        #1;
        if (rst_n && (sda_oe != oe_prev) && m_scl) r10_bad++;
        oe_prev = sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        m_sda = 1'b1; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        m_sda = 1'b0; wcyc(Q);
        m_scl = 1'b0; wcyc(Q);
    endtask

    task automatic m_stop;
        m_sda = 1'b0; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        m_sda = 1'b1; wcyc(Q);
    endtask

    task automatic m_bit_w(input logic b, input bit gl);
        m_sda = b; wcyc(Q / 2);
        if (gl) begin m_scl = 1'b1; wcyc(GL); m_scl = 1'b0; end
        wcyc(Q / 2);
        m_scl = 1'b1; wcyc(Q);
        if (gl) begin m_sda = ~b; wcyc(GL); m_sda = b; end
        wcyc(Q);
        m_scl = 1'b0; wcyc(Q);
    endtask

    task automatic m_bit_r(output logic b);
        m_sda = 1'b1; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        b = sda_line; wcyc(Q);
        m_scl = 1'b0; wcyc(Q);
    endtask

    task automatic m_send(input logic [7:0] d, input bit gl, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_w(d[i], gl);
        m_bit_r(b);
        ack = ~b;
    endtask

    task automatic m_recv(output logic [7:0] d, input bit ack);
        for (int i = 7; i >= 0; i--) m_bit_r(d[i]);
        m_bit_w(~ack, 1'b0);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic [31:0] d,
                            input bit gl, input bit wait_done, input string req);
        logic ack;
        m_start;
        m_send(DEV_W, 1'b0, ack);   check({req, " device ack"}, ack, 1);
        m_send(a[15:8], gl, ack);   check({req, " addr hi ack"}, ack, 1);
        m_send(a[7:0], gl, ack);    check({req, " addr lo ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            m_send(d[31-8*i -: 8], gl, ack);
            check({req, " data ack"}, ack, 1);
        end
        m_stop;
        if (wait_done) wcyc(WC + 200);
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input logic [31:0] e,
                           input string req);
        logic ack;
        logic [7:0] b;
        m_start;
        m_send(DEV_W, 1'b0, ack); check({req, " device ack"}, ack, 1);
        m_send(a[15:8], 1'b0, ack); check({req, " addr hi ack"}, ack, 1);
        m_send(a[7:0], 1'b0, ack);  check({req, " addr lo ack"}, ack, 1);
        m_start;
        m_send(DEV_R, 1'b0, ack); check({req, " read device ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            m_recv(b, i != n - 1);
            check({req, " read byte"}, b, e[31-8*i -: 8]);
        end
        m_stop;
        wcyc(4);
        check("R9 released after NACK and STOP", sda_oe, 0);
    endtask

    task automatic t_powerup;
        logic ack;
        wcyc(5);
        check("R1 sda_oe at reset", sda_oe, 0);
        m_start;
        m_send(DEV_W, 1'b0, ack);
        check("R1 no ACK before power-up delay", ack, 0);
        m_stop;
        wcyc(PU);
    endtask

    task automatic t_page_write;
        logic ack;
        do_write(16'h0010, 4, 32'h11223344, 1'b0, 1'b0, "R4 write");
        m_start;
        m_send(DEV_W, 1'b0, ack);
        check("R6 NACK during write cycle", ack, 0);
        m_stop;
        wcyc(WC);
        m_start;
        m_send(DEV_W, 1'b0, ack);
        check("R6 ACK after write cycle", ack, 1);
        m_stop;
    endtask

    task automatic t_random_read;
        do_read(16'h0010, 4, 32'h11223344, "R7 R8 random and sequential read");
    endtask

    task automatic t_page_wrap;
        do_write(16'h003E, 4, 32'hA1A2A3A4, 1'b0, 1'b1, "R5 write across page end");
        do_read(16'h0000, 2, 32'hA3A40000, "R5 wrapped bytes at page start");
        do_read(16'h003E, 2, 32'hA1A20000, "R5 bytes at page end");
    endtask

    task automatic t_rollover;
        do_write(16'h3FFE, 2, 32'hB1B20000, 1'b0, 1'b1, "R4 aliased high address");
        do_read(16'h00FE, 3, 32'hB1B2A300, "R8 rollover to cell 0");
    endtask

    task automatic t_wrong_device;
        logic ack;
        m_start;
        m_send(8'hA0, 1'b0, ack);
        check("R3 NACK for strap mismatch", ack, 0);
        m_send(8'h00, 1'b0, ack);
        check("R3 following byte ignored", ack, 0);
        m_stop;
        m_start;
        m_send(8'hBA, 1'b0, ack);
        check("R3 NACK for wrong prefix", ack, 0);
        m_stop;
    endtask

    task automatic t_glitch;
        do_write(16'h0020, 1, 32'h5A000000, 1'b1, 1'b1, "R2 write with short spikes");
        do_read(16'h0020, 1, 32'h5A000000, "R2 data intact after spikes");
    endtask

    initial begin
        wcyc(10);
        rst_n = 1'b1;
        t_powerup;
        t_page_write;
        t_random_read;
        t_page_wrap;
        t_rollover;
        t_wrong_device;
        t_glitch;
        check("R10 drive changes only while SCL low", r10_bad, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog all requirements actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule